// File: doc/BRIEF.md
# Set-Associative Cache Statistics Engine

This block models a set-associative cache that holds tags only, with true LRU replacement. It takes at most one access per cycle. Each access carries a type and a byte address. The block decides hit or miss and updates its per-set recency order and dirty bits. It keeps separate instruction and data counters for accesses, misses and replacements.

It also counts memory traffic in 32-bit words, in three counters:
- words fetched on allocating misses;
- words copied back from dirty victims;
- single-word writes that go straight to memory.

Two static inputs select the write policy (write-back or write-through) and the allocation policy (write-allocate or no-write-allocate). A flush command walks every set and charges each dirty line still resident as a copy-back. It then raises a one-cycle done pulse.

Top module: `cache_stats_engine`

## Requirements
- R1: The access type is decoded as 0 = data read, 1 = data write, 2 = instruction fetch. An access is taken when `req_valid` and `req_ready` are both high. The cycle after it is taken, `rsp_valid` is high and `rsp_hit` gives the outcome. Type 3 is ignored: no counter moves and `rsp_valid` stays low.
- R2: The block number is the byte address divided by `BLOCK_BYTES`. The set is the block number modulo `SETS`, and the whole block number is kept as the tag. Any address inside a resident block hits. A different block that maps to the same set misses.
- R3: A hit makes the line most recently used. A miss that allocates in a full set evicts the least recently used line and increments the replacement counter of its own stream (instruction or data).
- R4: A miss that allocates in a set with an invalid way fills that way without counting a replacement.
- R5: With write-back selected, a write hit or an allocating write miss marks the line dirty. Evicting a dirty line adds `BLOCK_BYTES/4` to `copyback_words`.
- R6: With no-write-allocate selected, a write miss counts as a data miss. It installs nothing and evicts nothing, and it adds one to `write_words`.
- R7: With write-through selected, every data write, hit or miss, adds exactly one to `write_words`, and no line ever becomes dirty.
- R8: Every allocating miss adds `BLOCK_BYTES/4` to `fetch_words`. Hits and non-allocating write misses add nothing.
- R9: A flush adds `BLOCK_BYTES/4` to `copyback_words` for each resident dirty line and then clears those dirty bits. A second flush adds nothing. While the flush runs, `req_ready` is low. `flush_done` pulses for one cycle, `SETS` cycles after the cycle in which the flush is taken.
- R10: A synchronous active-low reset clears all counters and invalidates all lines. The access counters count every taken access of their stream, and the miss counters count each miss of their stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access present |
| req_ready | output | 1 | Block can take an access (low during flush) |
| req_type | input | 2 | 0 read, 1 write, 2 instruction fetch, 3 ignored |
| req_addr | input | ADDR_W | Byte address |
| cfg_write_back | input | 1 | 1 write-back, 0 write-through |
| cfg_write_alloc | input | 1 | 1 write-allocate, 0 no-write-allocate |
| flush_req | input | 1 | Start a dirty-line scan |
| flush_done | output | 1 | One-cycle pulse at the end of the scan |
| rsp_valid | output | 1 | Result of the previous cycle's access |
| rsp_hit | output | 1 | That access hit |
| i_access_cnt | output | CNT_W | Instruction accesses |
| i_miss_cnt | output | CNT_W | Instruction misses |
| i_repl_cnt | output | CNT_W | Instruction replacements |
| d_access_cnt | output | CNT_W | Data accesses |
| d_miss_cnt | output | CNT_W | Data misses |
| d_repl_cnt | output | CNT_W | Data replacements |
| fetch_words | output | CNT_W | Demand-fetch traffic in words |
| copyback_words | output | CNT_W | Copy-back traffic in words |
| write_words | output | CNT_W | Direct write traffic in words |

## Verification
The hardest case to reach from the ports is an eviction whose victim is dirty. It needs a full set, a write hit that leaves a line dirty, and later accesses that make that same line least recently used. The vector table builds this up in one two-way set. It interleaves reads and writes to three blocks that map to that set, so that both a clean victim and a dirty victim are chosen, and it closes with a flush that must find exactly one dirty line left. Reset then brings the block back, and the other policy combinations are checked with short directed sequences.

// File: rtl/cache_stats_engine.sv
module cache_stats_engine #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 4,
  parameter int SETS        = 16,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_write_back,
  input  logic              cfg_write_alloc,
  input  logic              flush_req,
  output logic              flush_done,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  i_access_cnt,
  output logic [CNT_W-1:0]  i_miss_cnt,
  output logic [CNT_W-1:0]  i_repl_cnt,
  output logic [CNT_W-1:0]  d_access_cnt,
  output logic [CNT_W-1:0]  d_miss_cnt,
  output logic [CNT_W-1:0]  d_repl_cnt,
  output logic [CNT_W-1:0]  fetch_words,
  output logic [CNT_W-1:0]  copyback_words,
  output logic [CNT_W-1:0]  write_words
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam logic [CNT_W-1:0] WORD_INC = CNT_W'(BLOCK_BYTES / 4);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic             flushing_q;
  logic [SET_W-1:0] scan_q;

  wire              accept = req_valid && req_ready;
  wire              is_wr  = (req_type == 2'd1);
  wire              is_if  = (req_type == 2'd2);
  wire              known  = (req_type != 2'd3);
  wire [SET_W-1:0]  set_idx = req_addr[OFF_W +: SET_W];
  wire [TAG_W-1:0]  blk     = req_addr[ADDR_W-1:OFF_W];

  logic             hit, free_found;
  logic [WAY_W-1:0] hit_way, victim;

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    free_found = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (valid_q[set_idx][w] && tag_q[set_idx][w] == blk) begin
        hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    for (int w = 0; w < WAYS; w++)
      if (!valid_q[set_idx][w] && !free_found) begin
        free_found = 1'b1;
        victim = WAY_W'(w);
      end
    if (!free_found)
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_idx][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
  end

  wire              alloc   = hit || !(is_wr && !cfg_write_alloc);
  wire [WAY_W-1:0]  sel_way = hit ? hit_way : victim;
  wire              full    = &valid_q[set_idx];

  assign req_ready = !flushing_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          age_q[s][w] <= WAY_W'(w);
        end
      end
      flushing_q <= 1'b0;
      scan_q <= '0;
      flush_done <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit <= 1'b0;
      i_access_cnt <= '0; i_miss_cnt <= '0; i_repl_cnt <= '0;
      d_access_cnt <= '0; d_miss_cnt <= '0; d_repl_cnt <= '0;
      fetch_words <= '0; copyback_words <= '0; write_words <= '0;
    end else begin
      rsp_valid <= 1'b0;
      flush_done <= 1'b0;
      if (flushing_q) begin
        copyback_words <= copyback_words
          + WORD_INC * CNT_W'($countones(valid_q[scan_q] & dirty_q[scan_q]));
        dirty_q[scan_q] <= '0;
        scan_q <= scan_q + 1'b1;
        if (scan_q == SET_W'(SETS - 1)) begin
          flushing_q <= 1'b0;
          flush_done <= 1'b1;
        end
      end else if (flush_req) begin
        flushing_q <= 1'b1;
        scan_q <= '0;
      end
      if (accept && known) begin
        rsp_valid <= 1'b1;
        rsp_hit <= hit;
        if (is_if) begin
          i_access_cnt <= i_access_cnt + ONE;
          if (!hit) i_miss_cnt <= i_miss_cnt + ONE;
          if (!hit && full) i_repl_cnt <= i_repl_cnt + ONE;
        end else begin
          d_access_cnt <= d_access_cnt + ONE;
          if (!hit) d_miss_cnt <= d_miss_cnt + ONE;
          if (!hit && alloc && full) d_repl_cnt <= d_repl_cnt + ONE;
        end
        if (alloc) begin
          for (int w = 0; w < WAYS; w++)
            if (WAY_W'(w) == sel_way) age_q[set_idx][w] <= '0;
            else if (age_q[set_idx][w] < age_q[set_idx][sel_way])
              age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
        end
        if (!hit && alloc) begin
          valid_q[set_idx][sel_way] <= 1'b1;
          tag_q[set_idx][sel_way] <= blk;
          dirty_q[set_idx][sel_way] <= is_wr && cfg_write_back;
          fetch_words <= fetch_words + WORD_INC;
          if (full && dirty_q[set_idx][sel_way])
            copyback_words <= copyback_words + WORD_INC;
        end
        if (hit && is_wr && cfg_write_back) dirty_q[set_idx][sel_way] <= 1'b1;
        if (is_wr && (!cfg_write_back || !alloc)) write_words <= write_words + ONE;
      end
    end
  end

  // R10
  miss_le_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_miss_cnt <= d_access_cnt && i_miss_cnt <= i_access_cnt);

  // R3
  repl_le_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_repl_cnt <= d_miss_cnt && i_repl_cnt <= i_miss_cnt);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  // R1
  ignored_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_type == 2'd3) |=> (!rsp_valid && $stable(d_access_cnt) && $stable(i_access_cnt)));

  // R10
  ifetch_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_type == 2'd2) |=> (i_access_cnt == $past(i_access_cnt) + ONE));
endmodule

// File: tb/cache_stats_engine_tb_top.sv
module cache_stats_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_type = 2'd0;
  logic [31:0] req_addr = '0;
  logic cfg_write_back = 1'b1;
  logic cfg_write_alloc = 1'b1;
  logic flush_req = 1'b0;
  logic flush_done, rsp_valid, rsp_hit;
  logic [31:0] i_acc, i_miss, i_repl, d_acc, d_miss, d_repl, f_w, cb_w, wr_w;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cache_stats_engine #(.ADDR_W(32), .BLOCK_BYTES(16), .WAYS(2), .SETS(4), .CNT_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_addr(req_addr), .cfg_write_back(cfg_write_back),
    .cfg_write_alloc(cfg_write_alloc), .flush_req(flush_req), .flush_done(flush_done),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .i_access_cnt(i_acc), .i_miss_cnt(i_miss), .i_repl_cnt(i_repl),
    .d_access_cnt(d_acc), .d_miss_cnt(d_miss), .d_repl_cnt(d_repl),
    .fetch_words(f_w), .copyback_words(cb_w), .write_words(wr_w));

  // [15:14] type, [12] expected hit, [11:0] address
  localparam logic [15:0] VEC [10] = '{
    16'h0000, 16'h0040, 16'h1000, 16'h5000, 16'h0080,
    16'h8010, 16'h0040, 16'h9010, 16'h5080, 16'h0000};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic access(logic [1:0] t, logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic flush(int exp_cycles);
    int n = 0;
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    check("R9 ready low in flush", {31'd0, req_ready}, 32'd0);
    while (!flush_done && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R9 done delay", n, exp_cycles);
    @(negedge clk);
    check("R9 done single pulse", {31'd0, flush_done}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R10 reset d_access", d_acc, 0);
    check("R10 reset copyback", cb_w, 0);
    check("R10 reset ready", {31'd0, req_ready}, 1);

    // write-back, write-allocate: R3 R4 R5 R8 walk in one 2-way set
    for (int i = 0; i < 10; i++) begin
      access(VEC[i][15:14], {20'd0, VEC[i][11:0]});
      check($sformatf("R1 rsp_valid vec%0d", i), {31'd0, rsp_valid}, 1);
      check($sformatf("R3 hit vec%0d", i), {31'd0, rsp_hit}, {31'd0, VEC[i][12]});
    end
    check("R10 d_access", d_acc, 8);
    check("R10 d_miss", d_miss, 5);
    check("R3 d_repl", d_repl, 3);
    check("R10 i_access", i_acc, 2);
    check("R10 i_miss", i_miss, 1);
    check("R4 i_repl", i_repl, 0);
    check("R8 fetch words", f_w, 24);
    check("R5 dirty victim copyback", cb_w, 4);
    check("R5 no write words in wb", wr_w, 0);
    flush(4);
    check("R9 flush copyback", cb_w, 8);
    flush(4);
    check("R9 second flush adds nothing", cb_w, 8);

    // write-through, no-write-allocate
    cfg_write_back = 1'b0; cfg_write_alloc = 1'b0;
    do_reset();
    access(2'd1, 32'h000);
    check("R6 write miss hit flag", {31'd0, rsp_hit}, 0);
    check("R6 write miss counted", d_miss, 1);
    check("R6 write miss word", wr_w, 1);
    check("R6 no fetch", f_w, 0);
    access(2'd0, 32'h000);
    check("R6 not installed", {31'd0, rsp_hit}, 0);
    check("R8 read fetch", f_w, 4);
    access(2'd1, 32'h000);
    check("R7 write hit", {31'd0, rsp_hit}, 1);
    check("R7 write hit word", wr_w, 2);
    access(2'd0, 32'h040);
    access(2'd0, 32'h080);
    check("R3 wt replacement", d_repl, 1);
    check("R7 no dirty eviction", cb_w, 0);
    access(2'd0, 32'h040);
    check("R3 MRU kept", {31'd0, rsp_hit}, 1);
    access(2'd3, 32'h040);
    check("R1 type3 no rsp", {31'd0, rsp_valid}, 0);
    check("R1 type3 no count", d_acc, 6);
    flush(4);
    check("R7 flush finds nothing", cb_w, 0);

    // write-back, no-write-allocate, address mapping
    cfg_write_back = 1'b1; cfg_write_alloc = 1'b0;
    do_reset();
    access(2'd1, 32'h000);
    check("R6 wb nwa write word", wr_w, 1);
    check("R6 wb nwa no fetch", f_w, 0);
    access(2'd0, 32'h000);
    check("R6 wb nwa miss after write", {31'd0, rsp_hit}, 0);
    access(2'd0, 32'h00C);
    check("R2 same block hits", {31'd0, rsp_hit}, 1);
    access(2'd0, 32'h100);
    check("R2 other tag same set misses", {31'd0, rsp_hit}, 0);
    check("R4 free way no repl", d_repl, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule